// File: doc/BRIEF.md
# CAN Controller Mode Configuration Register

This block holds the 32-bit mode configuration word of a CAN controller and runs the mode sequencing behind it. A plain write port updates the disable, freeze-enable, halt, soft-reset, FIFO-enable, local-priority, abort-enable, ID-acceptance and highest-mailbox fields. A read port returns the whole word, including the live status bits.

From the stored fields the block drives these outputs:
- clock enables for the protocol engine and the mailbox manager;
- a freeze request;
- a flag saying the receive FIFO has claimed the low mailboxes;
- a per-mailbox usable mask.

The protocol engine reports back through acknowledge inputs for freeze, low power and soft-reset completion. An external debug-stop input can also request freeze.

Bit numbering inside the word is big-endian. Position 0, the most significant bit and vector index 31, holds the disable field. All positions below are given as vector indices.

Top module: `can_mode_ctrl`

## Requirements
- R1: After reset, the disable, freeze-enable and halt fields equal parameter DIS_RST, and not-ready reads the inverse of DIS_RST. The highest-mailbox field reads 0x0F and every other field reads 0. With DIS_RST=0 the first word read after reset is 0x0800000F.
- R2: The protocol-engine and mailbox-manager clock enables are both the inverse of the stored disable field. They update within two clock edges of the write.
- R3: The freeze request is 1 only when freeze-enable is 1 and either halt is 1 or the debug-stop input is high. It updates one edge after its inputs change.
- R4: Writing freeze-enable to 0 drops the freeze request by the second edge after the write, even with halt still 1.
- R5: Writing 1 to the soft-reset bit sets it, and it stays at 1 while the completion input is low. On the edge where completion is seen, it self-clears and every field except disable returns to its R1 value. That edge ignores any write.
- R6: While FIFO-enable is 1, the FIFO flag output is 1 and mailboxes 0 to 7 are cleared in the usable mask.
- R7: Mailbox i is marked usable exactly when i is no greater than the highest-mailbox field and R6 does not exclude it.
- R8: The freeze-acknowledge and low-power-acknowledge read bits follow their handshake inputs one edge later, and writes to those positions have no effect.
- R9: Outside reset and the soft-reset edge, not-ready is the registered OR of disable, freeze-acknowledge and low-power-acknowledge.
- R10: Field positions are:
  - disable 31, freeze-enable 30, FIFO-enable 29, halt 28;
  - not-ready 27, soft-reset 25, freeze-ack 24, low-power-ack 20;
  - local-priority 13, abort-enable 12, ID-acceptance 9:8, highest-mailbox 5:0.

  All other positions read 0 and ignore writes. Read data is registered one edge after the state it shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered configuration word with status |
| dbg_halt | input | 1 | Debug-stop request |
| frz_ack_in | input | 1 | Freeze acknowledge from protocol engine |
| lp_ack_in | input | 1 | Low-power acknowledge from protocol engine |
| srst_done | input | 1 | Soft-reset sequence complete |
| pe_clk_en | output | 1 | Protocol engine clock enable |
| mb_clk_en | output | 1 | Mailbox manager clock enable |
| freeze_req | output | 1 | Freeze request |
| fifo_excl | output | 1 | Low mailboxes claimed by the receive FIFO |
| mb_usable | output | NUM_MB | Per-mailbox usable mask |

## Verification
The hardest case to reach is a soft reset taking effect while the block is disabled, frozen and holding non-default fields. Only in that case do the preserved disable bit and the reset fields differ visibly.

The bench reaches it in three steps:
1. It writes an all-ones word, which sets every field, arms the soft reset and raises the freeze request.
2. It holds the completion input low and checks that the soft-reset bit stays pending.
3. It pulses completion for one cycle and checks that disable survives while every other field, the freeze request and the mailbox mask return to their reset values.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
  localparam int WORD_W   = 32;
  localparam int MAXMB_W  = 6;
  localparam int IDAM_W   = 2;

  localparam int B_DIS    = 31;
  localparam int B_FRZEN  = 30;
  localparam int B_FIFO   = 29;
  localparam int B_HALT   = 28;
  localparam int B_NRDY   = 27;
  localparam int B_SRST   = 25;
  localparam int B_FACK   = 24;
  localparam int B_LACK   = 20;
  localparam int B_LPRIO  = 13;
  localparam int B_ABORT  = 12;
  localparam int B_IDAM   = 8;
  localparam int B_MAXMB  = 0;

  localparam logic [MAXMB_W-1:0] MAXMB_RST = MAXMB_W'(15);

  typedef struct packed {
    logic               dis;
    logic               frz_en;
    logic               fifo_en;
    logic               halt;
    logic               lprio;
    logic               abort_en;
    logic [IDAM_W-1:0]  idam;
    logic [MAXMB_W-1:0] max_mb;
  } mode_fields_t;

  function automatic mode_fields_t fields_reset(input logic dis_val);
    mode_fields_t f;
    f.dis      = dis_val;
    f.frz_en   = dis_val;
    f.fifo_en  = 1'b0;
    f.halt     = dis_val;
    f.lprio    = 1'b0;
    f.abort_en = 1'b0;
    f.idam     = '0;
    f.max_mb   = MAXMB_RST;
    return f;
  endfunction

  function automatic logic [WORD_W-1:0] pack_word(
    input mode_fields_t f, input logic nrdy, input logic srst,
    input logic fack, input logic lack);
    logic [WORD_W-1:0] w;
    w = '0;
    w[B_DIS]   = f.dis;
    w[B_FRZEN] = f.frz_en;
    w[B_FIFO]  = f.fifo_en;
    w[B_HALT]  = f.halt;
    w[B_NRDY]  = nrdy;
    w[B_SRST]  = srst;
    w[B_FACK]  = fack;
    w[B_LACK]  = lack;
    w[B_LPRIO] = f.lprio;
    w[B_ABORT] = f.abort_en;
    w[B_IDAM +: IDAM_W]   = f.idam;
    w[B_MAXMB +: MAXMB_W] = f.max_mb;
    return w;
  endfunction
endpackage

// File: rtl/can_mode_regfile.sv
module can_mode_regfile
  import can_mode_pkg::*;
#(
  parameter logic DIS_RST = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              srst_done,
  output mode_fields_t      fields,
  output logic              srst_q,
  output logic              srst_apply
);
  mode_fields_t f_q;

  assign srst_apply = srst_q & srst_done;
  assign fields     = f_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      f_q    <= fields_reset(DIS_RST);
      srst_q <= 1'b0;
    end else if (srst_apply) begin
      f_q     <= fields_reset(DIS_RST);
      f_q.dis <= f_q.dis;
      srst_q  <= 1'b0;
    end else if (wr_en) begin
      f_q.dis      <= wr_data[B_DIS];
      f_q.frz_en   <= wr_data[B_FRZEN];
      f_q.fifo_en  <= wr_data[B_FIFO];
      f_q.halt     <= wr_data[B_HALT];
      f_q.lprio    <= wr_data[B_LPRIO];
      f_q.abort_en <= wr_data[B_ABORT];
      f_q.idam     <= wr_data[B_IDAM +: IDAM_W];
      f_q.max_mb   <= wr_data[B_MAXMB +: MAXMB_W];
      if (wr_data[B_SRST]) srst_q <= 1'b1;
    end
  end
endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq #(
  parameter logic DIS_RST = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic dis,
  input  logic frz_en,
  input  logic halt,
  input  logic dbg_halt,
  input  logic frz_ack_in,
  input  logic lp_ack_in,
  input  logic srst_apply,
  output logic freeze_req,
  output logic frz_ack_q,
  output logic lp_ack_q,
  output logic nrdy_q,
  output logic pe_clk_en,
  output logic mb_clk_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      freeze_req <= 1'b0;
      frz_ack_q  <= 1'b0;
      lp_ack_q   <= 1'b0;
      nrdy_q     <= ~DIS_RST;
      pe_clk_en  <= ~DIS_RST;
      mb_clk_en  <= ~DIS_RST;
    end else begin
      freeze_req <= frz_en & (halt | dbg_halt);
      frz_ack_q  <= frz_ack_in;
      lp_ack_q   <= lp_ack_in;
      nrdy_q     <= srst_apply ? ~DIS_RST : (dis | frz_ack_q | lp_ack_q);
      pe_clk_en  <= ~dis;
      mb_clk_en  <= ~dis;
    end
  end
endmodule

// File: rtl/can_mb_map.sv
module can_mb_map
  import can_mode_pkg::*;
#(
  parameter int NUM_MB  = 64,
  parameter int FIFO_MB = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fifo_en,
  input  logic [MAXMB_W-1:0] max_mb,
  output logic               fifo_excl,
  output logic [NUM_MB-1:0]  mb_usable
);
  logic [NUM_MB-1:0] usable_d;

  for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
    if (i < FIFO_MB) begin : g_low
      assign usable_d[i] = (32'(i) <= 32'(max_mb)) && !fifo_en;
    end else begin : g_high
      assign usable_d[i] = (32'(i) <= 32'(max_mb));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_excl <= 1'b0;
      mb_usable <= '0;
    end else begin
      fifo_excl <= fifo_en;
      mb_usable <= usable_d;
    end
  end
endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
  import can_mode_pkg::*;
#(
  parameter logic DIS_RST = 1'b0,
  parameter int   NUM_MB  = 64,
  parameter int   FIFO_MB = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  input  logic              dbg_halt,
  input  logic              frz_ack_in,
  input  logic              lp_ack_in,
  input  logic              srst_done,
  output logic              pe_clk_en,
  output logic              mb_clk_en,
  output logic              freeze_req,
  output logic              fifo_excl,
  output logic [NUM_MB-1:0] mb_usable
);
  mode_fields_t fields;
  logic srst_q, srst_apply, frz_ack_q, lp_ack_q, nrdy_q;

  can_mode_regfile #(.DIS_RST(DIS_RST)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .srst_done(srst_done), .fields(fields), .srst_q(srst_q),
    .srst_apply(srst_apply)
  );

  can_mode_seq #(.DIS_RST(DIS_RST)) u_seq (
    .clk(clk), .rst(rst), .dis(fields.dis), .frz_en(fields.frz_en),
    .halt(fields.halt), .dbg_halt(dbg_halt), .frz_ack_in(frz_ack_in),
    .lp_ack_in(lp_ack_in), .srst_apply(srst_apply),
    .freeze_req(freeze_req), .frz_ack_q(frz_ack_q), .lp_ack_q(lp_ack_q),
    .nrdy_q(nrdy_q), .pe_clk_en(pe_clk_en), .mb_clk_en(mb_clk_en)
  );

  can_mb_map #(.NUM_MB(NUM_MB), .FIFO_MB(FIFO_MB)) u_map (
    .clk(clk), .rst(rst), .fifo_en(fields.fifo_en), .max_mb(fields.max_mb),
    .fifo_excl(fifo_excl), .mb_usable(mb_usable)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= pack_word(fields_reset(DIS_RST), ~DIS_RST, 1'b0, 1'b0, 1'b0);
    else     rd_data <= pack_word(fields, nrdy_q, srst_q, frz_ack_q, lp_ack_q);
  end
endmodule

// File: rtl/can_mode_ctrl_chk.sv
module can_mode_ctrl_chk #(
  parameter int NUM_MB  = 64,
  parameter int FIFO_MB = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [31:0]       wr_data,
  input logic [31:0]       rd_data,
  input logic              srst_done,
  input logic              srst_q,
  input logic              frz_ack_in,
  input logic              frz_ack_q,
  input logic              pe_clk_en,
  input logic              freeze_req,
  input logic              fifo_excl,
  input logic [NUM_MB-1:0] mb_usable
);
  localparam logic [31:0] RSV_MASK = 32'h04EF_CCC0;

  assert_clk_en_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !srst_q) |=> ##1 (pe_clk_en == !$past(wr_data[31], 2)));

  assert_freeze_exit_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !srst_q && !wr_data[30]) |=> ##1 !freeze_req);

  assert_srst_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (srst_q && !srst_done) |=> srst_q);

  assert_srst_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (srst_q && srst_done) |=> !srst_q);

  assert_fifo_mask_R6: assert property (@(posedge clk) disable iff (rst)
    fifo_excl |-> (mb_usable[FIFO_MB-1:0] == '0));

  assert_ack_follow_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (frz_ack_q == $past(frz_ack_in)));

  assert_reserved_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_data & RSV_MASK) == 32'h0);
endmodule

bind can_mode_ctrl can_mode_ctrl_chk #(.NUM_MB(NUM_MB), .FIFO_MB(FIFO_MB)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .srst_done(srst_done), .srst_q(srst_q), .frz_ack_in(frz_ack_in),
  .frz_ack_q(frz_ack_q), .pe_clk_en(pe_clk_en), .freeze_req(freeze_req),
  .fifo_excl(fifo_excl), .mb_usable(mb_usable)
);

// File: tb/test_can_mode_ctrl.sv
module test_can_mode_ctrl;
  localparam int NMB = 64;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic dbg_halt = 1'b0, frz_ack_in = 1'b0, lp_ack_in = 1'b0, srst_done = 1'b0;
  logic pe_clk_en, mb_clk_en, freeze_req, fifo_excl;
  logic [NMB-1:0] mb_usable;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  can_mode_ctrl #(.DIS_RST(1'b0), .NUM_MB(NMB), .FIFO_MB(8)) i_can_mode_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .dbg_halt(dbg_halt), .frz_ack_in(frz_ack_in), .lp_ack_in(lp_ack_in),
    .srst_done(srst_done), .pe_clk_en(pe_clk_en), .mb_clk_en(mb_clk_en),
    .freeze_req(freeze_req), .fifo_excl(fifo_excl), .mb_usable(mb_usable)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit dis, input bit frz, input bit fen,
                                     input bit halt, input bit srst, input logic [5:0] mx);
    logic [31:0] w = '0;
    w[31] = dis; w[30] = frz; w[29] = fen; w[28] = halt; w[25] = srst; w[5:0] = mx;
    return w;
  endfunction

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(rd_data == 32'h0800_000F, "R1 reset word", rd_data, 32'h0800_000F);
    chk(pe_clk_en && mb_clk_en, "R1 clock enables after reset", {pe_clk_en, mb_clk_en}, 2'b11);
    chk(!freeze_req, "R1 freeze request after reset", freeze_req, 0);
    settle();
    chk(rd_data[27] == 1'b0, "R9 not-ready clears when enabled", rd_data[27], 0);
    chk(mb_usable == 64'h0000_0000_0000_FFFF, "R7 reset mask", mb_usable, 64'hFFFF);
  endtask

  task automatic t_status();
    frz_ack_in = 1'b1; settle();
    chk(rd_data[24] == 1'b1, "R8 freeze ack follows input", rd_data[24], 1);
    chk(rd_data[27] == 1'b1, "R9 not-ready while frozen", rd_data[27], 1);
    wr(mk(0, 0, 0, 0, 0, 6'h0F) | 32'h0010_0000); settle();
    chk(rd_data[24] == 1'b1 && rd_data[20] == 1'b0, "R8 status ignores writes",
        {rd_data[24], rd_data[20]}, 2'b10);
    frz_ack_in = 1'b0; lp_ack_in = 1'b1; settle();
    chk(rd_data[20] && !rd_data[24] && rd_data[27], "R8 R9 low-power ack",
        {rd_data[20], rd_data[24], rd_data[27]}, 3'b101);
    lp_ack_in = 1'b0; settle();
    chk(rd_data[27] == 1'b0, "R9 not-ready released", rd_data[27], 0);
  endtask

  task automatic t_clk_gate();
    wr(mk(1, 0, 0, 0, 0, 6'h0F)); settle();
    chk(!pe_clk_en && !mb_clk_en, "R2 disable gates clocks", {pe_clk_en, mb_clk_en}, 2'b00);
    chk(rd_data[27] == 1'b1, "R9 not-ready while disabled", rd_data[27], 1);
    wr(mk(0, 0, 0, 0, 0, 6'h0F)); settle();
    chk(pe_clk_en && mb_clk_en, "R2 enable restores clocks", {pe_clk_en, mb_clk_en}, 2'b11);
  endtask

  task automatic t_freeze();
    wr(mk(0, 0, 0, 1, 0, 6'h0F)); settle();
    chk(!freeze_req, "R3 halt without enable", freeze_req, 0);
    wr(mk(0, 1, 0, 0, 0, 6'h0F)); settle();
    chk(!freeze_req, "R3 enable without request", freeze_req, 0);
    dbg_halt = 1'b1; settle();
    chk(freeze_req, "R3 debug stop freezes", freeze_req, 1);
    dbg_halt = 1'b0; wr(mk(0, 1, 0, 1, 0, 6'h0F)); settle();
    chk(freeze_req, "R3 halt freezes", freeze_req, 1);
    wr(mk(0, 0, 0, 1, 0, 6'h0F)); settle();
    chk(!freeze_req, "R4 enable cleared exits freeze", freeze_req, 0);
    chk(rd_data[28] == 1'b1, "R4 halt still set", rd_data[28], 1);
  endtask

  task automatic t_fifo();
    wr(mk(0, 0, 1, 0, 0, 6'h0F)); settle();
    chk(fifo_excl && mb_usable == 64'h0000_0000_0000_FF00, "R6 fifo excludes low mailboxes",
        mb_usable, 64'hFF00);
    wr(mk(0, 0, 1, 0, 0, 6'h03)); settle();
    chk(mb_usable == 64'h0, "R6 R7 all below limit excluded", mb_usable, 64'h0);
    wr(mk(0, 0, 0, 0, 0, 6'h3F)); settle();
    chk(!fifo_excl && mb_usable == '1, "R7 full range", mb_usable, '1);
    wr(mk(0, 0, 1, 0, 0, 6'h3F)); settle();
    chk(mb_usable == ~64'hFF, "R6 full range with fifo", mb_usable, ~64'hFF);
    wr(mk(0, 0, 0, 0, 0, 6'h00)); settle();
    chk(mb_usable == 64'h1, "R7 single mailbox", mb_usable, 64'h1);
  endtask

  task automatic t_all_ones();
    wr(32'hFFFF_FFFF); settle();
    chk(rd_data == 32'hFA00_333F, "R10 layout and reserved bits", rd_data, 32'hFA00_333F);
    chk(freeze_req, "R3 freeze with all fields set", freeze_req, 1);
  endtask

  task automatic t_soft_reset();
    settle();
    chk(rd_data[25] == 1'b1, "R5 soft reset pending", rd_data[25], 1);
    @(negedge clk); srst_done = 1'b1; wr_en = 1'b1; wr_data = mk(0, 1, 1, 1, 0, 6'h3F);
    @(negedge clk); srst_done = 1'b0; wr_en = 1'b0;
    settle();
    chk(rd_data == 32'h8800_000F, "R5 fields reset, disable kept", rd_data, 32'h8800_000F);
    chk(!freeze_req && !pe_clk_en, "R5 freeze dropped, still disabled",
        {freeze_req, pe_clk_en}, 2'b00);
    chk(mb_usable == 64'hFFFF && !fifo_excl, "R5 mask back to reset", mb_usable, 64'hFFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_status();
    t_clk_gate();
    t_freeze();
    t_fifo();
    t_all_ones();
    t_soft_reset();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule